// File: doc/BRIEF.md
# Double-Precision Rounding Packer

This block is the last step of a floating-point datapath. An upstream unit delivers its result in unpacked form: a class tag, a sign, a signed exponent without bias, and a 56-bit mantissa. In that mantissa the leading one sits at bit 55 and the three lowest bits hold the guard, round and sticky information. The packer adds the exponent bias, rounds in one of four modes, and renormalizes when rounding carries out. It then resolves overflow and gradual underflow, and emits a 64-bit IEEE-754 double word together with inexact, overflow and underflow status.

The block has a single register stage. An operand presented with `in_valid` in one cycle appears on the outputs after the next rising clock edge, with `out_valid` high. The three flags belong to that same result word. The datapath splits into two branches that are computed in parallel, and the biased exponent selects between them. The normal branch is taken when the biased exponent is positive. The subnormal branch is taken when it is zero or negative. Special class tags bypass both branches.

There are no states beyond the output register, so there are no named states or transitions. The only sequencing is `in_valid` moving to `out_valid` one cycle later.

Top module: `dp_round_pack`

## Requirements
- R1: Encodings. Class tag `in_cls`: 00 normal, 01 zero, 10 NaN, 11 infinity. Rounding mode `in_mode`: 00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Output word: bit 63 is the sign, bits 62..52 the biased exponent, bits 51..0 the fraction. A normal operand with unbiased exponent 0 and mantissa 1<<55 packs to 0x3FF0000000000000 with no flags.
- R2: Nearest mode adds 8 to the mantissa when bit 2 is set and either bits 1..0 are nonzero or bit 3 is set. Inexact is raised whenever bits 2..0 are nonzero.
- R3: Toward-zero mode leaves the mantissa unchanged and raises inexact when bits 2..0 are nonzero.
- R4: Toward +infinity adds 8 only to positive operands with nonzero bits 2..0. Toward -infinity adds 8 only to negative ones. Inexact is raised on nonzero bits 2..0 in either mode.
- R5: After rounding on the normal branch, a set bit 56 increments the biased exponent and the mantissa is shifted right by 4. Otherwise it is shifted right by 3. The fraction is the low 52 bits of the result.
- R6: If the final biased exponent is 2047 or more and the guard bit (bit 2 before rounding) is set, the result is a signed infinity and overflow is flagged.
- R7: If the final biased exponent is 2047 or more and the guard bit is clear, the result is exponent 2046 with an all-ones fraction, and overflow is not flagged.
- R8: If the biased exponent b is 0 or less and 1-b is at most 56, the mantissa is shifted right by 1-b, rounded, and then doubled. If bit 56 of the doubled value is set, the result is exponent 1 with fraction 0 and no underflow. Otherwise the exponent is 0, the fraction is the doubled value shifted right by 4, and underflow is flagged.
- R9: If 1-b exceeds 56, the result is a signed zero, underflow is flagged and inexact stays clear.
- R10: A zero tag packs exponent 0 and fraction 0. An infinity tag packs exponent 2047 and fraction 0. A NaN tag packs exponent 2047 and fraction 1. None of the three raises a flag.
- R11: The sign input always appears in bit 63. `out_valid` follows `in_valid` by one clock, and the flags are valid together with the word. After reset the word, the flags and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_cls | input | 2 | Class tag of the operand |
| in_sign | input | 1 | Operand sign |
| in_exp | input | IN_EXP_W (13) | Signed unbiased exponent |
| in_mant | input | FRAC_W+4 (56) | Mantissa, leading one at bit 55, guard/round/sticky in bits 2..0 |
| in_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result present |
| out_word | output | 1+EXPF_W+FRAC_W (64) | Packed double |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_overflow | output | 1 | Result overflowed to infinity |
| out_underflow | output | 1 | Result is subnormal or flushed to zero |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent field, a 52-bit fraction and a 13-bit signed exponent input. The 13-bit input covers exponents from about -4096 to +4095. That range reaches both ends of the design. At the high end, biased exponents go past 2047, so the infinity and saturation outcomes can be driven. At the low end, shift amounts go past 56, so flush-to-zero can be driven. The exact 56/57 shift boundary and the carry into the smallest normal are also within this range.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
    typedef enum logic [1:0] {
        CLS_NORM = 2'b00,
        CLS_ZERO = 2'b01,
        CLS_NAN  = 2'b10,
        CLS_INF  = 2'b11
    } opnd_cls_e;

    typedef enum logic [1:0] {
        RMD_NEAR = 2'b00,
        RMD_ZERO = 2'b01,
        RMD_UP   = 2'b10,
        RMD_DOWN = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/dpk_round_step.sv
module dpk_round_step
    import dpk_pkg::*;
#(
    parameter int W = 57
) (
    input  logic [W-1:0] m_in,
    input  logic         sign,
    input  logic [1:0]   mode,
    output logic [W-1:0] m_out,
    output logic         inexact
);
    logic low_nz;
    logic bump;

    always_comb begin
        low_nz = |m_in[2:0];
        unique case (rnd_mode_e'(mode))
            RMD_NEAR: bump = m_in[2] & ((|m_in[1:0]) | m_in[3]);
            RMD_ZERO: bump = 1'b0;
            RMD_UP:   bump = ~sign & low_nz;
            RMD_DOWN: bump = sign & low_nz;
        endcase
        m_out   = m_in + {{(W-4){1'b0}}, bump, 3'b000};
        inexact = low_nz;
    end
endmodule

// File: rtl/dpk_norm_path.sv
module dpk_norm_path #(
    parameter int MANT_W = 56,
    parameter int FRAC_W = 52,
    parameter int EXPF_W = 11,
    parameter int BE_W   = 15
) (
    input  logic [MANT_W-1:0]      mant,
    input  logic signed [BE_W-1:0] be,
    input  logic                   sign,
    input  logic [1:0]             mode,
    output logic [EXPF_W-1:0]      exp_f,
    output logic [FRAC_W-1:0]      frac_f,
    output logic                   inexact,
    output logic                   ovf
);
    localparam int W    = MANT_W + 1;
    localparam int EMAX = (1 << EXPF_W) - 1;

    logic [W-1:0] m_rnd;
    logic         carry;
    int           be_i;

    dpk_round_step #(.W(W)) u_rnd (
        .m_in    ({1'b0, mant}),
        .sign    (sign),
        .mode    (mode),
        .m_out   (m_rnd),
        .inexact (inexact)
    );

    always_comb begin
        carry = m_rnd[MANT_W];
        be_i  = int'(be) + (carry ? 1 : 0);
        ovf   = 1'b0;
        if (be_i >= EMAX) begin
            if (mant[2]) begin
                exp_f  = '1;
                frac_f = '0;
                ovf    = 1'b1;
            end else begin
                exp_f  = EXPF_W'(EMAX - 1);
                frac_f = '1;
            end
        end else begin
            exp_f  = EXPF_W'(be_i);
            frac_f = carry ? m_rnd[FRAC_W+3:4] : m_rnd[FRAC_W+2:3];
        end
    end

    logic unused_low;
    assign unused_low = ^m_rnd[2:0];
endmodule

// File: rtl/dpk_sub_path.sv
module dpk_sub_path #(
    parameter int MANT_W = 56,
    parameter int FRAC_W = 52,
    parameter int EXPF_W = 11,
    parameter int BE_W   = 15
) (
    input  logic [MANT_W-1:0]      mant,
    input  logic signed [BE_W-1:0] be,
    input  logic                   sign,
    input  logic [1:0]             mode,
    output logic [EXPF_W-1:0]      exp_f,
    output logic [FRAC_W-1:0]      frac_f,
    output logic                   inexact,
    output logic                   ux
);
    int                sh;
    logic [MANT_W-1:0] m_sh;
    logic [MANT_W-1:0] m_rnd;
    logic              rnd_ix;

    always_comb begin
        sh = 1 - int'(be);
        if (sh < 1 || sh > MANT_W) m_sh = '0;
        else                       m_sh = mant >> sh;
    end

    dpk_round_step #(.W(MANT_W)) u_rnd (
        .m_in    (m_sh),
        .sign    (sign),
        .mode    (mode),
        .m_out   (m_rnd),
        .inexact (rnd_ix)
    );

    always_comb begin
        if (sh > MANT_W) begin
            exp_f   = '0;
            frac_f  = '0;
            inexact = 1'b0;
            ux      = 1'b1;
        end else if (m_rnd[MANT_W-1]) begin
            exp_f   = EXPF_W'(1);
            frac_f  = '0;
            inexact = rnd_ix;
            ux      = 1'b0;
        end else begin
            exp_f   = '0;
            frac_f  = m_rnd[FRAC_W+2:3];
            inexact = rnd_ix;
            ux      = 1'b1;
        end
    end

    logic unused_low;
    assign unused_low = ^m_rnd[2:0];
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
    import dpk_pkg::*;
#(
    parameter int IN_EXP_W = 13,
    parameter int EXPF_W   = 11,
    parameter int FRAC_W   = 52
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_cls,
    input  logic                       in_sign,
    input  logic [IN_EXP_W-1:0]        in_exp,
    input  logic [FRAC_W+3:0]          in_mant,
    input  logic [1:0]                 in_mode,
    output logic                       out_valid,
    output logic [EXPF_W+FRAC_W:0]     out_word,
    output logic                       out_inexact,
    output logic                       out_overflow,
    output logic                       out_underflow
);
    localparam int MANT_W = FRAC_W + 4;
    localparam int WORD_W = 1 + EXPF_W + FRAC_W;
    localparam int BE_W   = IN_EXP_W + 2;
    localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;

    logic signed [BE_W-1:0] be_s;
    logic                   use_norm;

    assign be_s     = $signed({{2{in_exp[IN_EXP_W-1]}}, in_exp}) + $signed(BE_W'(BIAS));
    assign use_norm = !be_s[BE_W-1] && (be_s != '0);

    logic [EXPF_W-1:0] n_exp, s_exp, exp_n;
    logic [FRAC_W-1:0] n_frac, s_frac, frac_n;
    logic              n_ix, n_ovf, s_ix, s_ux;
    logic              ix_n, ov_n, ux_n;

    dpk_norm_path #(.MANT_W(MANT_W), .FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .BE_W(BE_W)) u_norm (
        .mant (in_mant), .be (be_s), .sign (in_sign), .mode (in_mode),
        .exp_f (n_exp), .frac_f (n_frac), .inexact (n_ix), .ovf (n_ovf)
    );

    dpk_sub_path #(.MANT_W(MANT_W), .FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .BE_W(BE_W)) u_sub (
        .mant (in_mant), .be (be_s), .sign (in_sign), .mode (in_mode),
        .exp_f (s_exp), .frac_f (s_frac), .inexact (s_ix), .ux (s_ux)
    );

    always_comb begin
        exp_n  = '0;
        frac_n = '0;
        ix_n   = 1'b0;
        ov_n   = 1'b0;
        ux_n   = 1'b0;
        unique case (opnd_cls_e'(in_cls))
            CLS_ZERO: ;
            CLS_NAN: begin
                exp_n  = '1;
                frac_n = FRAC_W'(1);
            end
            CLS_INF:  exp_n = '1;
            CLS_NORM: begin
                if (use_norm) begin
                    exp_n  = n_exp;
                    frac_n = n_frac;
                    ix_n   = n_ix;
                    ov_n   = n_ovf;
                end else begin
                    exp_n  = s_exp;
                    frac_n = s_frac;
                    ix_n   = s_ix;
                    ux_n   = s_ux;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_word      <= '0;
            out_inexact   <= 1'b0;
            out_overflow  <= 1'b0;
            out_underflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word      <= {in_sign, exp_n, frac_n};
                out_inexact   <= ix_n;
                out_overflow  <= ov_n;
                out_underflow <= ux_n;
            end
        end
    end

    // R11: result follows request by one clock, sign carried through
    a_r11_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[WORD_W-1] == $past(in_sign));
    // R10: special tags
    a_r10_nan_pack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == CLS_NAN) |=>
        (out_word[FRAC_W +: EXPF_W] == '1 && out_word[FRAC_W-1:0] == FRAC_W'(1)
         && !out_inexact && !out_overflow && !out_underflow));
    a_r10_zero_pack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == CLS_ZERO) |=> out_word[WORD_W-2:0] == '0);
    // R6: overflow only ever reports an infinity
    a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (out_word[FRAC_W +: EXPF_W] == '1 && out_word[FRAC_W-1:0] == '0));
    // R8: underflow only with a zero exponent field
    a_r8_ux_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_underflow |-> out_word[FRAC_W +: EXPF_W] == '0);
    a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_overflow && out_underflow));
endmodule

// File: tb/sim_dp_round_pack.sv
module sim_dp_round_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_cls = 2'b00;
    logic        in_sign = 1'b0;
    logic [12:0] in_exp = '0;
    logic [55:0] in_mant = '0;
    logic [1:0]  in_mode = 2'b00;
    logic        out_valid;
    logic [63:0] out_word;
    logic        out_inexact, out_overflow, out_underflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [66:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dp_round_pack u0 (
        .clk, .rst_n, .in_valid, .in_cls, .in_sign, .in_exp, .in_mant, .in_mode,
        .out_valid, .out_word, .out_inexact, .out_overflow, .out_underflow
    );

    function automatic logic [56:0] ref_rnd(logic [56:0] v, logic s, logic [1:0] md, inout logic ix);
        logic nz = (v[2:0] != 3'b000);
        logic up = 1'b0;
        if (md == 2'b00) up = v[2] && (v[1] || v[0] || v[3]);
        else if (md == 2'b10) up = !s && nz;
        else if (md == 2'b11) up = s && nz;
        ix = ix | nz;
        return up ? v + 57'd8 : v;
    endfunction

    function automatic logic [66:0] ref_pack(logic [1:0] cls, logic s, int e, logic [55:0] m, logic [1:0] md);
        logic [63:0] w = '0;
        logic ix = 1'b0, ov = 1'b0, ux = 1'b0, g;
        logic [56:0] v = {1'b0, m};
        int be, sh;
        logic [10:0] ef;
        case (cls)
            2'b01: w = {s, 63'd0};
            2'b10: w = {s, 11'h7ff, 52'd1};
            2'b11: w = {s, 11'h7ff, 52'd0};
            default: begin
                be = e + 1023;
                if (be > 0) begin
                    g = v[2];
                    v = ref_rnd(v, s, md, ix);
                    if (v[56]) begin be = be + 1; v = v >> 4; end
                    else v = v >> 3;
                    if (be >= 2047) begin
                        if (g) begin w = {s, 11'h7ff, 52'd0}; ov = 1'b1; end
                        else w = {s, 11'h7fe, {52{1'b1}}};
                    end else begin
                        ef = 11'(be);
                        w = {s, ef, v[51:0]};
                    end
                end else begin
                    sh = 1 - be;
                    if (sh > 56) begin w = {s, 63'd0}; ux = 1'b1; end
                    else begin
                        v = v >> sh;
                        v = ref_rnd(v, s, md, ix);
                        v = v << 1;
                        if (v[56]) w = {s, 11'd1, 52'd0};
                        else begin v = v >> 4; w = {s, 11'd0, v[51:0]}; ux = 1'b1; end
                    end
                end
            end
        endcase
        return {ux, ov, ix, w};
    endfunction

    task automatic drive(logic [1:0] cls, logic s, int e, logic [55:0] m, logic [1:0] md, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_cls = cls; in_sign = s; in_exp = 13'(e); in_mant = m; in_mode = md;
        exp_q.push_back(ref_pack(cls, s, e, m, md));
        tag_q.push_back(tag);
    endtask

    task automatic fail_line(string tag, logic [66:0] got, logic [66:0] want);
        errors++;
        $display("FAIL %s: got ux%0b ov%0b ix%0b %h, expected ux%0b ov%0b ix%0b %h",
                 tag, got[66], got[65], got[64], got[63:0], want[66], want[65], want[64], want[63:0]);
    endtask

    // monitor: compares each produced result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [66:0] got, want;
            string tag;
            got = {out_underflow, out_overflow, out_inexact, out_word};
            checks++;
            if (exp_q.size() == 0) fail_line("R11 unexpected result", got, '0);
            else begin
                want = exp_q.pop_front();
                tag = tag_q.pop_front();
                if (got !== want) fail_line(tag, got, want);
            end
        end
    end

    localparam logic [55:0] ONE = 56'h80_0000_0000_0000;

    initial begin
        logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, out_word, out_inexact, out_overflow, out_underflow} !== '0) begin
            errors++;
            $display("FAIL R11 reset: got %h/%b, expected 0", out_word, out_valid);
        end
        rst_n = 1'b1;
        drive(2'b00, 1'b0, 0, ONE, 2'b00, "R1 one");
        drive(2'b00, 1'b0, 3, ONE | 56'h4, 2'b00, "R2 tie even stays");
        drive(2'b00, 1'b0, 3, ONE | 56'hC, 2'b00, "R2 tie odd rounds up");
        drive(2'b00, 1'b1, 3, ONE | 56'h5, 2'b00, "R2 above half");
        drive(2'b00, 1'b0, 3, ONE | 56'h3, 2'b00, "R2 below half inexact");
        drive(2'b00, 1'b0, -5, ONE | 56'hF, 2'b01, "R3 toward zero");
        drive(2'b00, 1'b0, 7, ONE | 56'h1, 2'b10, "R4 up positive");
        drive(2'b00, 1'b1, 7, ONE | 56'h1, 2'b10, "R4 up negative");
        drive(2'b00, 1'b1, 7, ONE | 56'h2, 2'b11, "R4 down negative");
        drive(2'b00, 1'b0, 7, ONE | 56'h2, 2'b11, "R4 down positive");
        drive(2'b00, 1'b0, 10, {56{1'b1}}, 2'b00, "R5 carry renormalize");
        drive(2'b00, 1'b0, 1024, ONE | 56'h4, 2'b01, "R6 overflow guard set");
        drive(2'b00, 1'b1, 1023, {56{1'b1}}, 2'b00, "R6 carry into overflow");
        drive(2'b00, 1'b0, 1024, ONE | 56'h3, 2'b10, "R7 saturate guard clear");
        drive(2'b00, 1'b0, -1023, ONE, 2'b00, "R8 subnormal");
        drive(2'b00, 1'b0, -1023, {56{1'b1}}, 2'b00, "R8 rounds to smallest normal");
        drive(2'b00, 1'b1, -1040, ONE | 56'h3FFFF, 2'b11, "R8 deep subnormal");
        drive(2'b00, 1'b0, -1078, ONE, 2'b10, "R8 shift of 56");
        drive(2'b00, 1'b1, -1079, ONE, 2'b11, "R9 shift of 57 flushes");
        drive(2'b00, 1'b0, -3000, ONE | 56'h7, 2'b00, "R9 far flush");
        drive(2'b01, 1'b1, 500, ONE | 56'h7, 2'b10, "R10 zero tag");
        drive(2'b10, 1'b0, 0, 56'h7, 2'b00, "R10 nan tag");
        drive(2'b11, 1'b1, 0, 56'h7, 2'b11, "R10 infinity tag");
        for (int i = 0; i < 300; i++) begin
            logic [63:0] y;
            int e;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            y = x;
            x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
            e = int'(y[11:0] % 12'd2300) - 1150;
            drive((y[20:16] == 5'd0) ? y[22:21] : 2'b00, y[61], e, {1'b1, x[54:0]}, y[63:62],
                  "R2,R5,R8 sweep");
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 drain: got %0d pending valid=%b, expected 0 pending valid=0",
                     exp_q.size(), out_valid);
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule